// File: doc/BRIEF.md
# Serial Audio Port Event Controller

This block collects the event flags of the transmit side and the receive side of a multichannel serial audio port. The serializer and frame logic send it one-cycle pulses: underrun or overrun, unexpected frame sync, clock failure, data-port error, last slot, data ready and start of frame. It also receives a level that gives the parity of the current TDM slot. Each pulse sets a sticky flag in that direction's status register. Software clears a flag by writing 1 to its bit.

Each direction has its own event-enable register and drives one active-high, level-type interrupt line. The enable bits do not sit at the same positions as the status bits they gate. Enable bit 3 gates the data-port error in status bit 7, and enable bit 7 gates the start-of-frame flag in status bit 6.

A read-only summary error bit is the OR of the four error flags. It stays set until every one of them has been cleared. The slot-parity bit and the summary bit never raise an interrupt.

A simple register port gives access to all four registers. A write takes effect at the clock edge, and a read returns the current register contents combinationally.

Top module: `sap_evt_ctrl`

## Requirements
- R1: After reset, both status registers, both enable registers and both interrupt lines are 0.
- R2: An event pulse on `*_evt_i` sets a sticky flag, visible from the next cycle. Event bit 0 (underrun/overrun) goes to status bit 0, bit 1 (frame-sync error) to bit 1, bit 2 (clock failure) to bit 2, bit 3 (data-port error) to bit 7, bit 4 (last slot) to bit 4, bit 5 (data ready) to bit 5, and bit 6 (start of frame) to bit 6.
- R3: Writing 1 to a status flag bit clears that bit, and writing 0 leaves it unchanged. If a pulse and a clear for the same bit arrive in the same cycle, the bit stays set.
- R4: Status bit 8 (summary error) reads as the OR of status bits 0, 1, 2 and 7. It stays 1 until all four are clear.
- R5: Status bit 3 shows the slot-parity input as sampled at the previous clock edge (1 = odd slot).
- R6: Each enable register is writable in bits 0–5 and 7. Bit 0 gates status bit 0, bit 1 gates bit 1, bit 2 gates bit 2, bit 3 gates bit 7, bit 4 gates bit 4, bit 5 gates bit 5, and bit 7 gates bit 6. Bit 6 always reads 0.
- R7: An interrupt line is, one cycle late, the OR over the flags of that direction's status register ANDed with their enables. It stays high while any enabled flag is set.
- R8: Status bits 3 and 8 have no enable and never drive an interrupt. Writes to status bits 3 and 8 are ignored.
- R9: Transmit and receive have separate flags, enables and interrupt lines. Activity on one side leaves the other side unchanged.
- R10: Register map: address bits [3:2] select transmit status (0x0), transmit enable (0x4), receive status (0x8) and receive enable (0xC). Address bits [1:0] are ignored. Unused read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_evt_i | input | 7 | Transmit event pulses (encoding in R2) |
| tx_slot_odd_i | input | 1 | Transmit current slot is odd |
| rx_evt_i | input | 7 | Receive event pulses (encoding in R2) |
| rx_slot_odd_i | input | 1 | Receive current slot is odd |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_tx_o | output | 1 | Transmit interrupt, active high |
| irq_rx_o | output | 1 | Receive interrupt, active high |

## Verification
Directed patterns come first.
- Single pulses on each event bit tell apart the event-to-status-bit mapping, including the two swapped positions.
- A single enable bit paired with its own flag, and with a different flag, tells apart the enable-to-status mapping.
- Errors cleared one at a time show that the summary bit holds until the last error is gone.
- A pulse in the same cycle as its clear separates set-priority from clear-priority.
- Traffic on one side only separates the two directions.

Sparse random pulses mixed with random writes to all four registers then compare every cycle's readback and both interrupt lines against a bench model. This model catches ordering and timing errors that the directed cases miss.

// File: rtl/sap_evt_pkg.sv
`timescale 1ns/1ps
package sap_evt_pkg;
  localparam int unsigned EVT_N    = 7;
  localparam int unsigned STAT_W   = 9;
  localparam int unsigned EN_W     = 8;
  localparam int unsigned WR_W     = 8;   // register bits that writes can reach
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 4;
  localparam int unsigned DIR_N    = 2;
  localparam int unsigned SLOT_BIT = 3;
  localparam int unsigned SUM_BIT  = 8;
  // event order: unf/ovf, sync, ckfail, dperr, last, data, sof
  localparam logic [EVT_N-1:0] ERR_MASK = 7'b000_1111;

  typedef enum logic [1:0] {
    SEL_TX_STAT = 2'd0,
    SEL_TX_EN   = 2'd1,
    SEL_RX_STAT = 2'd2,
    SEL_RX_EN   = 2'd3
  } reg_sel_e;

  function automatic int unsigned stat_pos(int unsigned evt);
    return (evt == 3) ? 7 : evt;
  endfunction

  function automatic int unsigned en_pos(int unsigned evt);
    return (evt == 6) ? 7 : evt;
  endfunction
endpackage

// File: rtl/sap_evt_side.sv
`timescale 1ns/1ps
module sap_evt_side
  import sap_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_N-1:0]  evt_i,
  input  logic              slot_odd_i,
  input  logic              stat_we_i,
  input  logic              en_we_i,
  input  logic [WR_W-1:0]   wdata_i,
  output logic [STAT_W-1:0] stat_o,
  output logic [EN_W-1:0]   en_o,
  output logic              irq_o
);
  logic [EVT_N-1:0] flag_q;
  logic [EVT_N-1:0] en_q;
  logic             slot_q;
  logic             irq_q;

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    localparam int unsigned SP = stat_pos(i);
    localparam int unsigned EP = en_pos(i);
    logic clr;
    assign clr = stat_we_i & wdata_i[SP];

    // set wins over clear
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[i] <= 1'b0;
      else         flag_q[i] <= (flag_q[i] & ~clr) | evt_i[i];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        en_q[i] <= 1'b0;
      else if (en_we_i)   en_q[i] <= wdata_i[EP];
    end

    assign stat_o[SP] = flag_q[i];
    assign en_o[EP]   = en_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      slot_q <= slot_odd_i;
      irq_q  <= |(flag_q & en_q);
    end
  end

  assign stat_o[SLOT_BIT] = slot_q;
  assign stat_o[SUM_BIT]  = |(flag_q & ERR_MASK);
  assign en_o[6]          = 1'b0;
  assign irq_o            = irq_q;
endmodule

// File: rtl/sap_evt_regif.sv
`timescale 1ns/1ps
module sap_evt_regif
  import sap_evt_pkg::*;
(
  input  logic                          we_i,
  input  logic [1:0]                    sel_i,
  input  logic [DIR_N-1:0][STAT_W-1:0]  stat_i,
  input  logic [DIR_N-1:0][EN_W-1:0]    en_i,
  output logic [DIR_N-1:0]              stat_we_o,
  output logic [DIR_N-1:0]              en_we_o,
  output logic [DATA_W-1:0]             rdata_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  for (genvar d = 0; d < DIR_N; d++) begin : g_we
    assign stat_we_o[d] = we_i & (sel_i == 2'(2 * d));
    assign en_we_o[d]   = we_i & (sel_i == 2'(2 * d + 1));
  end

  always_comb begin
    unique case (sel)
      SEL_TX_STAT: rdata_o = DATA_W'(stat_i[0]);
      SEL_TX_EN:   rdata_o = DATA_W'(en_i[0]);
      SEL_RX_STAT: rdata_o = DATA_W'(stat_i[1]);
      default:     rdata_o = DATA_W'(en_i[1]);
    endcase
  end
endmodule

// File: rtl/sap_evt_ctrl.sv
`timescale 1ns/1ps
module sap_evt_ctrl
  import sap_evt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EVT_N-1:0]  tx_evt_i,
  input  logic              tx_slot_odd_i,
  input  logic [EVT_N-1:0]  rx_evt_i,
  input  logic              rx_slot_odd_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_tx_o,
  output logic              irq_rx_o
);
  logic [DIR_N-1:0][EVT_N-1:0]  evt;
  logic [DIR_N-1:0]             slot;
  logic [DIR_N-1:0][STAT_W-1:0] stat;
  logic [DIR_N-1:0][EN_W-1:0]   en;
  logic [DIR_N-1:0]             stat_we, en_we, irq;
  logic [STAT_W-1:0]            tx_stat, rx_stat;
  logic [EN_W-1:0]              tx_en, rx_en;
  logic                         unused_bits;

  assign evt  = {rx_evt_i, tx_evt_i};
  assign slot = {rx_slot_odd_i, tx_slot_odd_i};
  assign unused_bits = ^{reg_wdata_i[DATA_W-1:WR_W], reg_addr_i[1:0]};

  sap_evt_regif u_regif (
    .we_i      (reg_we_i),
    .sel_i     (reg_addr_i[3:2]),
    .stat_i    (stat),
    .en_i      (en),
    .stat_we_o (stat_we),
    .en_we_o   (en_we),
    .rdata_o   (reg_rdata_o)
  );

  for (genvar d = 0; d < DIR_N; d++) begin : g_dir
    sap_evt_side u_side (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .evt_i      (evt[d]),
      .slot_odd_i (slot[d]),
      .stat_we_i  (stat_we[d]),
      .en_we_i    (en_we[d]),
      .wdata_i    (reg_wdata_i[WR_W-1:0]),
      .stat_o     (stat[d]),
      .en_o       (en[d]),
      .irq_o      (irq[d])
    );
  end

  assign tx_stat  = stat[0];
  assign rx_stat  = stat[1];
  assign tx_en    = en[0];
  assign rx_en    = en[1];
  assign irq_tx_o = irq[0];
  assign irq_rx_o = irq[1];
endmodule

// File: rtl/sap_evt_chk.sv
`timescale 1ns/1ps
module sap_evt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [1:0] sel_i,
  input logic [6:0] tx_evt_i,
  input logic       tx_slot_odd_i,
  input logic [8:0] tx_stat,
  input logic [8:0] rx_stat,
  input logic [7:0] tx_en,
  input logic [7:0] rx_en,
  input logic       irq_tx_o,
  input logic       irq_rx_o
);
  logic tx_hit, rx_hit, tx_stat_wr, unused_chk;
  assign tx_hit = |(tx_stat[7:0] & {tx_en[3], tx_en[7], tx_en[5], tx_en[4], 1'b0, tx_en[2:0]});
  assign rx_hit = |(rx_stat[7:0] & {rx_en[3], rx_en[7], rx_en[5], rx_en[4], 1'b0, rx_en[2:0]});
  assign tx_stat_wr = reg_we_i && (sel_i == 2'd0);
  assign unused_chk = ^{tx_evt_i[6:4], tx_evt_i[2:1]};

  // R2
  dperr_lands_bit7_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt_i[3] |=> tx_stat[7]);
  // R2
  unf_lands_bit0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_evt_i[0] |=> tx_stat[0]);
  // R3
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stat[1] && !tx_stat_wr) |=> tx_stat[1]);
  // R4
  summary_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_stat[8] && !tx_stat_wr) |=> tx_stat[8]);
  // R5
  slot_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (tx_stat[3] == $past(tx_slot_odd_i)));
  // R6
  en_gap_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en[6] && !rx_en[6]);
  // R7
  tx_irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_hit |=> irq_tx_o);
  // R7
  tx_irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_hit |=> !irq_tx_o);
  // R9
  rx_irq_own_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_hit |=> irq_rx_o);
  // R9
  rx_irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_hit |=> !irq_rx_o);
endmodule

bind sap_evt_ctrl sap_evt_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .sel_i         (reg_addr_i[3:2]),
  .tx_evt_i      (tx_evt_i),
  .tx_slot_odd_i (tx_slot_odd_i),
  .tx_stat       (tx_stat),
  .rx_stat       (rx_stat),
  .tx_en         (tx_en),
  .rx_en         (rx_en),
  .irq_tx_o      (irq_tx_o),
  .irq_rx_o      (irq_rx_o)
);

// File: tb/sap_evt_ctrl_bench.sv
`timescale 1ns/1ps
module sap_evt_ctrl_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  tx_evt_i = '0, rx_evt_i = '0;
  logic        tx_slot_odd_i = 1'b0, rx_slot_odd_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_tx_o, irq_rx_o;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // model: flag bits kept at status positions, bit 3 unused
  logic [7:0] m_st[2];
  logic [7:0] m_en[2];
  bit         m_slot[2];
  bit         m_irq[2];

  always #10 clk_i = ~clk_i;

  sap_evt_ctrl u_sap_evt_ctrl (.*);

  function automatic logic [7:0] ev2st(input logic [6:0] ev);
    return {ev[3], ev[6], ev[5], ev[4], 1'b0, ev[2:0]};
  endfunction

  function automatic bit hit(input logic [7:0] st, input logic [7:0] en);
    return |(st & {en[3], en[7], en[5], en[4], 1'b0, en[2:0]});
  endfunction

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    int d = a[3];
    if (a[2]) return {24'd0, m_en[d]};
    return {23'd0, |{m_st[d][7], m_st[d][2:0]}, m_st[d][7:4], m_slot[d], m_st[d][2:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic check_read(input logic [3:0] a, input string tag);
    reg_addr_i = a;
    #1;
    chk(tag, reg_rdata_o, exp_read(a));
  endtask

  task automatic check_irq(input string tag);
    chk({tag, " irq_tx"}, {31'd0, irq_tx_o}, {31'd0, m_irq[0]});
    chk({tag, " irq_rx"}, {31'd0, irq_rx_o}, {31'd0, m_irq[1]});
  endtask

  // one cycle: drive at negedge, update model at posedge, idle at next negedge
  task automatic step(input logic [6:0] tev, input logic [6:0] rev, input bit ts, input bit rs,
                      input bit we, input logic [3:0] a, input logic [31:0] wd);
    logic [6:0] ev[2];
    bit         sl[2];
    bit         h[2];
    ev[0] = tev; ev[1] = rev; sl[0] = ts; sl[1] = rs;
    tx_evt_i = tev; rx_evt_i = rev; tx_slot_odd_i = ts; rx_slot_odd_i = rs;
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    @(posedge clk_i);
    for (int d = 0; d < 2; d++) h[d] = hit(m_st[d], m_en[d]);
    for (int d = 0; d < 2; d++) begin
      logic [7:0] clr = 8'd0;
      if (we && a[3] == d[0] && !a[2]) clr = wd[7:0] & 8'hF7;
      if (we && a[3] == d[0] && a[2])  m_en[d] = wd[7:0] & 8'hBF;
      m_st[d]   = (m_st[d] & ~clr) | ev2st(ev[d]);
      m_slot[d] = sl[d];
      m_irq[d]  = h[d];
    end
    @(negedge clk_i);
    tx_evt_i = '0; rx_evt_i = '0; reg_we_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(7'd0, 7'd0, tx_slot_odd_i, rx_slot_odd_i, 1'b0, 4'd0, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int d = 0; d < 2; d++) begin m_st[d] = '0; m_en[d] = '0; m_slot[d] = 0; m_irq[d] = 0; end
    repeat (3) @(negedge clk_i);
    // R1 reset state, checked while reset is held
    for (int a = 0; a < 16; a += 4) check_read(4'(a), "R1 reset reg");
    check_irq("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 each event position on transmit
    for (int i = 0; i < 7; i++) begin
      step(7'(1 << i), 7'd0, 0, 0, 1'b0, 4'd0, 32'd0);
      check_read(4'h0, "R2 single event");
      step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h0FF);
    end
    // R3 write 0 keeps, write 1 clears, set beats clear
    step(7'h7F, 7'd0, 0, 0, 1'b0, 4'd0, 32'd0);
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h000);
    check_read(4'h0, "R3 write zero keeps");
    step(7'h02, 7'd0, 0, 0, 1'b1, 4'h0, 32'h003);
    check_read(4'h0, "R3 set wins over clear");
    // R4 summary holds until the last error is gone
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h001);
    check_read(4'h0, "R4 summary after first clear");
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h006);
    check_read(4'h0, "R4 summary with dperr only");
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h080);
    check_read(4'h0, "R4 summary cleared");
    // R5 slot parity
    step(7'd0, 7'd0, 1, 0, 1'b0, 4'd0, 32'd0);
    check_read(4'h0, "R5 slot odd");
    step(7'd0, 7'd0, 0, 1, 1'b0, 4'd0, 32'd0);
    check_read(4'h0, "R5 slot even");
    check_read(4'h8, "R5 rx slot odd");
    // R8 writes to bits 3 and 8 ignored
    step(7'h01, 7'd0, 1, 0, 1'b0, 4'd0, 32'd0);
    step(7'd0, 7'd0, 1, 0, 1'b1, 4'h0, 32'h108);
    check_read(4'h0, "R8 read-only bits");
    // R6 enable layout
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h4, 32'hFFFF_FFFF);
    check_read(4'h4, "R6 enable bit 6 reads 0");
    // R8 slot and summary alone raise nothing
    step(7'd0, 7'd0, 1, 0, 1'b1, 4'h0, 32'h0FF);
    step(7'h01, 7'd0, 1, 0, 1'b0, 4'd0, 32'd0);
    step(7'd0, 7'd0, 1, 0, 1'b1, 4'h0, 32'h001);
    idle(2);
    check_irq("R8 no irq from slot");
    // R7 enable 3 gates status 7, enable 7 gates status 6
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h4, 32'h008);
    step(7'h40, 7'd0, 0, 0, 1'b0, 4'd0, 32'd0);
    idle(1);
    check_irq("R7 sof not gated by en3");
    step(7'h08, 7'd0, 0, 0, 1'b0, 4'd0, 32'd0);
    check_irq("R7 irq one cycle late");
    idle(1);
    check_irq("R7 dperr gated by en3");
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h0C0);
    idle(1);
    check_irq("R7 irq drops after clear");
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h4, 32'h080);
    step(7'h40, 7'd0, 0, 0, 1'b0, 4'd0, 32'd0);
    idle(1);
    check_irq("R7 sof gated by en7");
    // R9 receive activity leaves transmit alone
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'h0, 32'h0FF);
    step(7'd0, 7'd0, 0, 0, 1'b1, 4'hC, 32'h0FF);
    step(7'd0, 7'h7F, 0, 1, 1'b0, 4'd0, 32'd0);
    idle(1);
    check_read(4'h0, "R9 tx status untouched");
    check_read(4'h8, "R9 rx status set");
    check_irq("R9 separate lines");
    // R10 low address bits ignored
    check_read(4'hB, "R10 unaligned rx status");
    check_read(4'h6, "R10 unaligned tx enable");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] r0 = $urandom, r1 = $urandom, r2 = $urandom, r3 = $urandom;
      logic [6:0] tev = r0[6:0] & r1[6:0] & r2[6:0];
      logic [6:0] rev = r0[14:8] & r1[14:8] & r2[14:8];
      bit we = (r3[3:0] < 4'd5);
      step(tev, rev, r3[4], r3[5], we, r3[11:8], r1);
      check_irq("R7 random");
      check_read(r3[15:12], "R10 random readback");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule